// File: doc/BRIEF.md
# Trap and Interrupt Control Unit

This unit is the privileged control block of a simple in-order processor. It owns the machine status word, the cause word, the saved exception PC, the faulting-address register, the exception vector, and an instruction-driven timer with a compare value. Each time the pipeline signals an instruction boundary, the unit decides whether a trap must be taken. A trap is taken either because an enabled interrupt is pending or because the current instruction raised a synchronous exception. On a trap it redirects fetch to the exception vector in the same cycle.

Pending interrupts are recorded inside the cause word, beside the trap code. External lines and the timer set these bits, and they stay set until software clears them. On trap entry the unit changes only the code field of cause. It turns off trap enable, raises supervisor mode and keeps the old supervisor bit. Software reads and writes every register through a small register port, addressed by a 3-bit selector.

Top module: `trap_ctrl_unit`

## Requirements
- R1: After synchronous reset the status word reads 0x0000000A (supervisor bit 1 and wide-mode bit 3 set), and cause, count and compare read 0. redirect_valid stays low while no trap is taken.
- R2: Cause bits 15:8 are the pending bits and bits 7:0 the trap code. irq_lines[i] high at a clock edge sets cause bit 8+i, which stays set afterwards.
- R3: An interrupt trap is taken at an instruction boundary only when status bit 0 (trap enable) is 1 and the pending bits ANDed with the status mask in bits 15:8 are nonzero. Otherwise no interrupt trap is taken.
- R4: A synchronous exception at an instruction boundary traps whatever the trap-enable bit. It writes exc_code into the cause code field and exc_addr into the bad-address register.
- R5: When an enabled interrupt and an exception meet at the same boundary, the interrupt is taken. The code becomes IRQ_CODE (default 0x10) and the bad-address register is left unchanged.
- R6: On trap entry, status bit 0 is cleared, bit 1 is set, bit 2 takes the old value of bit 1, and all other status bits are kept.
- R7: On trap entry only cause bits 7:0 are rewritten. The pending bits are preserved.
- R8: In the cycle of a trap, redirect_valid is high and redirect_pc equals the exception vector. The exception PC register captures cur_pc.
- R9: Count increments on every instruction boundary. When its value before the increment equals compare, cause bit 15 is set.
- R10: Writing compare clears cause bit 15. Writing cause replaces the code and pending fields, with external lines asserted in that same cycle ORed into the pending field.
- R11: Register selectors are: 0 status, 1 cause, 2 exception PC, 3 bad address, 4 count, 5 compare, 6 vector. A write is visible on csr_rdata from the next cycle.
- R12: A register write to status, cause code, exception PC or bad address in the same cycle as a trap is dropped in favour of the trap's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_step | input | 1 | Instruction boundary strobe |
| cur_pc | input | XLEN | PC of the instruction at the boundary |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 8 | Code of the exception |
| exc_addr | input | XLEN | Faulting address of the exception |
| irq_lines | input | 7 | External interrupt lines |
| csr_we | input | 1 | Register write enable |
| csr_addr | input | 3 | Register selector |
| csr_wdata | input | XLEN | Register write data |
| csr_rdata | output | XLEN | Register read data for the selected register |
| redirect_valid | output | 1 | Trap taken, fetch must redirect |
| redirect_pc | output | XLEN | Redirect target (exception vector) |
| status_out | output | 32 | Current status word |
| cause_out | output | 32 | Current cause word |

## Verification
The timer compare match and an interrupt trap entry can land on the same instruction boundary. Both then act on the cause word in one edge: the timer sets pending bit 15 while the trap rewrites the code field. The bench loads count and compare with equal values, enables an already pending line, and steps once. It expects a redirect in that cycle and a cause word that holds the interrupt code, the old pending bits and the new timer bit together. A second collision puts a register write and an exception trap in the same cycle. The bench judges it by whether the saved PC holds the trap's value.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

    localparam int WORD_W    = 32;
    localparam int CODE_W    = 8;
    localparam int NPEND     = 8;
    localparam int NEXT_IRQ  = 7;
    localparam int TIMER_IDX = 7;

    localparam int ST_ET     = 0;
    localparam int ST_S      = 1;
    localparam int ST_PS     = 2;
    localparam int ST_SX     = 3;
    localparam int ST_IM_LO  = 8;

    localparam int CA_PEND_LO = 8;

    localparam logic [WORD_W-1:0] STATUS_RST =
        (WORD_W'(1) << ST_S) | (WORD_W'(1) << ST_SX);

    typedef enum logic [2:0] {
        SEL_STATUS  = 3'd0,
        SEL_CAUSE   = 3'd1,
        SEL_EPC     = 3'd2,
        SEL_BADADDR = 3'd3,
        SEL_COUNT   = 3'd4,
        SEL_COMPARE = 3'd5,
        SEL_EVEC    = 3'd6
    } reg_sel_e;

    typedef struct packed {
        logic              take;
        logic              is_irq;
        logic [CODE_W-1:0] code;
    } trap_req_t;

    function automatic logic [WORD_W-1:0] enter_status(input logic [WORD_W-1:0] old);
        logic [WORD_W-1:0] nxt;
        nxt        = old;
        nxt[ST_ET] = 1'b0;
        nxt[ST_PS] = old[ST_S];
        nxt[ST_S]  = 1'b1;
        return nxt;
    endfunction

    function automatic logic [WORD_W-1:0] pack_cause(input logic [NPEND-1:0]  pend,
                                                     input logic [CODE_W-1:0] code);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CA_PEND_LO +: NPEND] = pend;
        w[CODE_W-1:0]          = code;
        return w;
    endfunction

endpackage

// File: rtl/tcu_timer.sv
module tcu_timer
    import tcu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             cnt_we,
    input  logic             cmp_we,
    input  logic [XLEN-1:0]  wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] compare,
    output logic             hit
);

    logic [CNT_W-1:0] count_q, cmp_q;

    assign hit     = step && !cnt_we && (count_q == cmp_q);
    assign count   = count_q;
    assign compare = cmp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            cmp_q   <= '0;
        end else begin
            if (cnt_we)
                count_q <= wdata[CNT_W-1:0];
            else if (step)
                count_q <= count_q + 1'b1;
            if (cmp_we)
                cmp_q <= wdata[CNT_W-1:0];
        end
    end

    assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
        (step && !cnt_we) |=> (count_q == $past(count_q) + 1'b1));

endmodule

// File: rtl/tcu_arbiter.sv
module tcu_arbiter
    import tcu_pkg::*;
#(
    parameter logic [CODE_W-1:0] IRQ_CODE = 8'h10
) (
    input  logic              step,
    input  logic              trap_en,
    input  logic [NPEND-1:0]  mask,
    input  logic [NPEND-1:0]  pend,
    input  logic              exc_req,
    input  logic [CODE_W-1:0] exc_code,
    output trap_req_t         trap
);

    logic [NPEND-1:0] effective;
    logic             irq_go, exc_go;

    always_comb begin
        effective   = pend & mask;
        irq_go      = step && trap_en && (|effective);
        exc_go      = step && exc_req;
        trap.take   = irq_go || exc_go;
        trap.is_irq = irq_go;
        trap.code   = irq_go ? IRQ_CODE : exc_code;
    end

endmodule

// File: rtl/tcu_csr_file.sv
module tcu_csr_file
    import tcu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  trap_req_t           trap,
    input  logic [XLEN-1:0]     cur_pc,
    input  logic [XLEN-1:0]     exc_addr,
    input  logic [NEXT_IRQ-1:0] irq_lines,
    input  logic                timer_hit,
    input  logic                we,
    input  logic [2:0]          sel,
    input  logic [XLEN-1:0]     wdata,
    output logic [WORD_W-1:0]   status,
    output logic [NPEND-1:0]    pend,
    output logic [CODE_W-1:0]   code,
    output logic [XLEN-1:0]     epc,
    output logic [XLEN-1:0]     badaddr,
    output logic [XLEN-1:0]     evec
);

    logic [WORD_W-1:0] status_q;
    logic [NPEND-1:0]  pend_q, pend_d;
    logic [CODE_W-1:0] code_q;
    logic [XLEN-1:0]   epc_q, bad_q, evec_q;
    logic              wr_status, wr_cause, wr_epc, wr_bad, wr_evec, wr_cmp;

    always_comb begin
        wr_status = we && (reg_sel_e'(sel) == SEL_STATUS);
        wr_cause  = we && (reg_sel_e'(sel) == SEL_CAUSE);
        wr_epc    = we && (reg_sel_e'(sel) == SEL_EPC);
        wr_bad    = we && (reg_sel_e'(sel) == SEL_BADADDR);
        wr_evec   = we && (reg_sel_e'(sel) == SEL_EVEC);
        wr_cmp    = we && (reg_sel_e'(sel) == SEL_COMPARE);
    end

    always_comb begin
        pend_d = wr_cause ? wdata[CA_PEND_LO +: NPEND] : pend_q;
        pend_d[NEXT_IRQ-1:0] = pend_d[NEXT_IRQ-1:0] | irq_lines;
        if (wr_cmp)
            pend_d[TIMER_IDX] = 1'b0;
        else
            pend_d[TIMER_IDX] = pend_d[TIMER_IDX] | timer_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= STATUS_RST;
            pend_q   <= '0;
            code_q   <= '0;
            epc_q    <= '0;
            bad_q    <= '0;
            evec_q   <= '0;
        end else begin
            pend_q <= pend_d;
            if (trap.take) begin
                status_q <= enter_status(status_q);
                code_q   <= trap.code;
                epc_q    <= cur_pc;
                if (!trap.is_irq)
                    bad_q <= exc_addr;
            end else begin
                if (wr_status) status_q <= wdata[WORD_W-1:0];
                if (wr_cause)  code_q   <= wdata[CODE_W-1:0];
                if (wr_epc)    epc_q    <= wdata;
                if (wr_bad)    bad_q    <= wdata;
            end
            if (wr_evec)
                evec_q <= wdata;
        end
    end

    assign status  = status_q;
    assign pend    = pend_q;
    assign code    = code_q;
    assign epc     = epc_q;
    assign badaddr = bad_q;
    assign evec    = evec_q;

    assert_trap_status_R6: assert property (@(posedge clk) disable iff (rst)
        trap.take |=> (!status_q[ST_ET] && status_q[ST_S]
                       && (status_q[ST_PS] == $past(status_q[ST_S]))));

    assert_pend_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (trap.take && !wr_cause && !wr_cmp) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    assert_irq_latch_R2: assert property (@(posedge clk) disable iff (rst)
        (irq_lines != '0) |=> ((pend_q[NEXT_IRQ-1:0] & $past(irq_lines)) == $past(irq_lines)));

    assert_timer_set_R9: assert property (@(posedge clk) disable iff (rst)
        (timer_hit && !wr_cmp) |=> pend_q[TIMER_IDX]);

    assert_irq_gate_R3: assert property (@(posedge clk) disable iff (rst)
        (trap.take && trap.is_irq) |->
            (status_q[ST_ET] && ((pend_q & status_q[ST_IM_LO +: NPEND]) != '0)));

    assert_epc_capture_R8: assert property (@(posedge clk) disable iff (rst)
        trap.take |=> (epc_q == $past(cur_pc)));

endmodule

// File: rtl/trap_ctrl_unit.sv
module trap_ctrl_unit
    import tcu_pkg::*;
#(
    parameter int                XLEN     = 32,
    parameter int                CNT_W    = 32,
    parameter logic [CODE_W-1:0] IRQ_CODE = 8'h10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                insn_step,
    input  logic [XLEN-1:0]     cur_pc,
    input  logic                exc_req,
    input  logic [CODE_W-1:0]   exc_code,
    input  logic [XLEN-1:0]     exc_addr,
    input  logic [NEXT_IRQ-1:0] irq_lines,
    input  logic                csr_we,
    input  logic [2:0]          csr_addr,
    input  logic [XLEN-1:0]     csr_wdata,
    output logic [XLEN-1:0]     csr_rdata,
    output logic                redirect_valid,
    output logic [XLEN-1:0]     redirect_pc,
    output logic [WORD_W-1:0]   status_out,
    output logic [WORD_W-1:0]   cause_out
);

    trap_req_t         trap;
    logic [WORD_W-1:0] status;
    logic [NPEND-1:0]  pend;
    logic [CODE_W-1:0] code;
    logic [XLEN-1:0]   epc, badaddr, evec;
    logic [CNT_W-1:0]  count, compare;
    logic              timer_hit, cnt_we, cmp_we;
    logic [WORD_W-1:0] cause_w;

    assign cnt_we  = csr_we && (reg_sel_e'(csr_addr) == SEL_COUNT);
    assign cmp_we  = csr_we && (reg_sel_e'(csr_addr) == SEL_COMPARE);
    assign cause_w = pack_cause(pend, code);

    tcu_timer #(.XLEN(XLEN), .CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .step    (insn_step),
        .cnt_we  (cnt_we),
        .cmp_we  (cmp_we),
        .wdata   (csr_wdata),
        .count   (count),
        .compare (compare),
        .hit     (timer_hit)
    );

    tcu_arbiter #(.IRQ_CODE(IRQ_CODE)) u_arb (
        .step     (insn_step),
        .trap_en  (status[ST_ET]),
        .mask     (status[ST_IM_LO +: NPEND]),
        .pend     (pend),
        .exc_req  (exc_req),
        .exc_code (exc_code),
        .trap     (trap)
    );

    tcu_csr_file #(.XLEN(XLEN)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .trap      (trap),
        .cur_pc    (cur_pc),
        .exc_addr  (exc_addr),
        .irq_lines (irq_lines),
        .timer_hit (timer_hit),
        .we        (csr_we),
        .sel       (csr_addr),
        .wdata     (csr_wdata),
        .status    (status),
        .pend      (pend),
        .code      (code),
        .epc       (epc),
        .badaddr   (badaddr),
        .evec      (evec)
    );

    always_comb begin
        unique case (reg_sel_e'(csr_addr))
            SEL_STATUS:  csr_rdata = XLEN'(status);
            SEL_CAUSE:   csr_rdata = XLEN'(cause_w);
            SEL_EPC:     csr_rdata = epc;
            SEL_BADADDR: csr_rdata = badaddr;
            SEL_COUNT:   csr_rdata = XLEN'(count);
            SEL_COMPARE: csr_rdata = XLEN'(compare);
            SEL_EVEC:    csr_rdata = evec;
            default:     csr_rdata = '0;
        endcase
    end

    assign redirect_valid = trap.take;
    assign redirect_pc    = evec;
    assign status_out     = status;
    assign cause_out      = cause_w;

    assert_redirect_step_R8: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> insn_step);

    assert_irq_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (redirect_valid && status[ST_ET] && ((pend & status[ST_IM_LO +: NPEND]) != '0))
            |=> (cause_out[CODE_W-1:0] == IRQ_CODE));

endmodule

// File: tb/trap_ctrl_unit_tb.sv
module trap_ctrl_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] VEC = 32'h8000_0100;

    logic        clk = 1'b0;
    logic        rst;
    logic        insn_step, exc_req, csr_we;
    logic [31:0] cur_pc, exc_addr, csr_wdata, csr_rdata, redirect_pc;
    logic [7:0]  exc_code;
    logic [6:0]  irq_lines;
    logic [2:0]  csr_addr;
    logic        redirect_valid;
    logic [31:0] status_out, cause_out;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_ctrl_unit u_dut (
        .clk(clk), .rst(rst), .insn_step(insn_step), .cur_pc(cur_pc),
        .exc_req(exc_req), .exc_code(exc_code), .exc_addr(exc_addr),
        .irq_lines(irq_lines), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .status_out(status_out), .cause_out(cause_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0; csr_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        csr_addr = a;
        #1;
        d = csr_rdata;
    endtask

    task automatic step(input logic [31:0] pc, input logic ex, input logic [7:0] c,
                        input logic [31:0] ad, output logic rv, output logic [31:0] rpc);
        insn_step = 1'b1; cur_pc = pc; exc_req = ex; exc_code = c; exc_addr = ad;
        #1;
        rv = redirect_valid; rpc = redirect_pc;
        @(negedge clk);
        insn_step = 1'b0; exc_req = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(3'd0, v); check("R1 status", v, 32'h0000_000A);
        rd(3'd1, v); check("R1 cause", v, 32'h0);
        rd(3'd4, v); check("R1 count", v, 32'h0);
        rd(3'd5, v); check("R1 compare", v, 32'h0);
        check("R1 redirect idle", {31'b0, redirect_valid}, 32'h0);
    endtask

    task automatic t_csr_rw;
        logic [31:0] v;
        wr(3'd5, 32'd1000);
        wr(3'd6, VEC);
        wr(3'd3, 32'h11);
        rd(3'd5, v); check("R11 compare rw", v, 32'd1000);
        rd(3'd6, v); check("R11 vector rw", v, VEC);
        rd(3'd3, v); check("R11 badaddr rw", v, 32'h11);
    endtask

    task automatic t_irq;
        logic v_rv; logic [31:0] v_pc, v;
        irq_lines = 7'b0000100;
        @(negedge clk);
        irq_lines = '0;
        check("R2 pending latched", cause_out, 32'h0000_0400);
        step(32'h40, 1'b0, 8'h0, 32'h0, v_rv, v_pc);
        check("R3 no trap with enable off", {31'b0, v_rv}, 32'h0);
        check("R2 pending sticky", cause_out, 32'h0000_0400);
        wr(3'd0, 32'h0000_0001);
        step(32'h42, 1'b0, 8'h0, 32'h0, v_rv, v_pc);
        check("R3 no trap when masked", {31'b0, v_rv}, 32'h0);
        wr(3'd0, 32'h0000_0401);
        step(32'h44, 1'b0, 8'h0, 32'h0, v_rv, v_pc);
        check("R8 redirect valid", {31'b0, v_rv}, 32'h1);
        check("R8 redirect target", v_pc, VEC);
        rd(3'd2, v); check("R8 epc", v, 32'h44);
        check("R7 cause code and pending", cause_out, 32'h0000_0410);
        check("R6 status entry from user", status_out, 32'h0000_0402);
    endtask

    task automatic t_priority;
        logic v_rv; logic [31:0] v_pc, v;
        wr(3'd0, 32'h0000_0403);
        step(32'h48, 1'b1, 8'h05, 32'hDEAD, v_rv, v_pc);
        check("R5 trap taken", {31'b0, v_rv}, 32'h1);
        check("R5 interrupt code wins", cause_out, 32'h0000_0410);
        rd(3'd3, v); check("R5 badaddr unchanged", v, 32'h11);
        check("R6 status entry from supervisor", status_out, 32'h0000_0406);
    endtask

    task automatic t_exception;
        logic v_rv; logic [31:0] v_pc, v;
        wr(3'd1, 32'h0);
        wr(3'd0, 32'h0);
        step(32'h60, 1'b1, 8'h03, 32'hBAD0, v_rv, v_pc);
        check("R4 exception traps with enable off", {31'b0, v_rv}, 32'h1);
        check("R4 cause code", cause_out, 32'h0000_0003);
        rd(3'd3, v); check("R4 badaddr", v, 32'hBAD0);
        check("R6 status after exception", status_out, 32'h0000_0002);
        rd(3'd2, v); check("R8 epc exception", v, 32'h60);
    endtask

    task automatic t_timer;
        logic v_rv; logic [31:0] v_pc, v;
        wr(3'd4, 32'd5);
        wr(3'd5, 32'd7);
        wr(3'd1, 32'h0);
        step(32'h80, 1'b0, 8'h0, 32'h0, v_rv, v_pc);
        step(32'h84, 1'b0, 8'h0, 32'h0, v_rv, v_pc);
        check("R9 no early timer bit", cause_out, 32'h0);
        step(32'h88, 1'b0, 8'h0, 32'h0, v_rv, v_pc);
        check("R9 timer bit set", cause_out, 32'h0000_8000);
        rd(3'd4, v); check("R9 count advanced", v, 32'd8);
        wr(3'd5, 32'd100);
        check("R10 compare write clears", cause_out, 32'h0);
        csr_we = 1'b1; csr_addr = 3'd1; csr_wdata = 32'h0000_0201; irq_lines = 7'b0000001;
        @(negedge clk);
        csr_we = 1'b0; irq_lines = '0;
        check("R10 cause write merged with line", cause_out, 32'h0000_0301);
    endtask

    task automatic t_collide;
        logic v_rv; logic [31:0] v_pc, v;
        wr(3'd4, 32'd9);
        wr(3'd5, 32'd9);
        wr(3'd0, 32'h0000_0101);
        step(32'h70, 1'b0, 8'h0, 32'h0, v_rv, v_pc);
        check("R3 trap on enabled pending", {31'b0, v_rv}, 32'h1);
        check("R7 R9 timer bit with trap code", cause_out, 32'h0000_8310);
        check("R6 status collide", status_out, 32'h0000_0102);
        rd(3'd4, v); check("R9 count after collide", v, 32'd10);
    endtask

    task automatic t_drop;
        logic [31:0] v;
        csr_we = 1'b1; csr_addr = 3'd2; csr_wdata = 32'h1234;
        insn_step = 1'b1; cur_pc = 32'h500; exc_req = 1'b1; exc_code = 8'h02; exc_addr = 32'h0;
        @(negedge clk);
        csr_we = 1'b0; insn_step = 1'b0; exc_req = 1'b0;
        rd(3'd2, v); check("R12 trap beats epc write", v, 32'h500);
        wr(3'd2, 32'h1234);
        rd(3'd2, v); check("R11 epc write alone", v, 32'h1234);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; insn_step = 1'b0; exc_req = 1'b0; csr_we = 1'b0;
        cur_pc = '0; exc_addr = '0; exc_code = '0; irq_lines = '0;
        csr_addr = '0; csr_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_csr_rw();
        t_irq();
        t_priority();
        t_exception();
        t_timer();
        t_collide();
        t_drop();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule